// File: doc/BRIEF.md
# Flash Command and Interrupt Register Front End

This block is the register front end that sits between a host register bus and the operation engines of a flash device. Through a small 16-bit register bus the host writes a command code, two configuration words and a buffer-selection word. It reads back those registers together with a controller status word and an interrupt status word. An accepted command goes to the engines as a one-cycle start pulse that carries the command code, the buffer address and the sector count. The engines answer with one-cycle done and error pulses. The block turns these pulses into interrupt and status bits, and it drives an interrupt pin and a ready pin.

The host must acknowledge each interrupt before it can issue another command. While the master interrupt bit is set, command writes have no effect. The host clears interrupt bits by writing an AND mask to the interrupt register. When that write leaves the master bit clear, all error bits in the status word clear as well. The configuration word selects the polarity of the interrupt pin. The two reset command codes return the registers to their warm-reset values, and they are the only commands accepted while an operation is still outstanding.

A small sequencer tracks the command flow. It has three states. SEQ_IDLE means no operation is outstanding. SEQ_ISSUE is the single cycle in which the start pulse is driven. SEQ_WAIT means an engine is working. The transitions are:
- launch: SEQ_IDLE to SEQ_ISSUE, on an accepted engine command.
- quick finish: SEQ_ISSUE to SEQ_IDLE, when a done pulse arrives in the issue cycle.
- hand-off: SEQ_ISSUE to SEQ_WAIT, otherwise.
- finish: SEQ_WAIT to SEQ_IDLE, on any done pulse.
- abort: any state to SEQ_IDLE, on an accepted reset command.

Top module: `flash_cmd_regs`

## Requirements
- R1: After the reset input is released, the registers read as follows: command 0x0000, configuration one 0x40C0, configuration two 0x0000, status 0x0000, interrupt 0x8080 and buffer select 0x0001. The interrupt pin and the ready pin are both high. The register offsets are 0 command, 1 configuration one, 2 configuration two, 3 status (writes ignored), 4 interrupt and 5 buffer select. Other offsets read 0.
- R2: Configuration one stores all 16 written bits, but it always reads back with bits 4:0 as zero. Configuration two reads back exactly what was written.
- R3: The interrupt pin equals interrupt bit 15 XOR the inverse of configuration-one bit 6. The ready pin equals configuration-one bit 7.
- R4: A write to the interrupt register replaces it with the old value ANDed with the written value. If bit 15 of that AND result is 0, status bits 13:10 clear in the same cycle.
- R5: A write to the command register while interrupt bit 15 is set changes nothing: the command register keeps its value and no start pulse is issued.
- R6: An accepted engine command stores the written value in the command register. The following cycle, it drives cmd_start high for exactly one cycle, with cmd_code equal to that value. The engine codes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0094, 0x0095, 0x0030, 0x0023, 0x0027, 0x002A, 0x002C, 0x0065, 0x0071 and 0x00B0.
- R7: An accepted code that is neither an engine code nor a reset code is stored, sets status bit 10 and interrupt bit 15, and issues no start pulse.
- R8: An accepted 0x00F0 or 0x00F3 performs a warm reset. All registers take their R1 values, except that interrupt becomes 0x8010. Done and error pulses in that same cycle are dropped.
- R9: Done pulses OR bits into the interrupt register after any AND mask of the same cycle. Load done sets bits 15 and 7, program done sets 15 and 6, erase done sets 15 and 5, and the plain done sets bit 15 only.
- R10: Error pulses set status bit 10 together with a specific bit: bit 13 for load, bit 12 for program and bit 11 for erase. They apply after any error clearing of the same cycle.
- R11: Buffer select keeps only bits 11:8 (the buffer address, driven on buf_addr) and bits 1:0 (the count field). sec_count equals the count field, except that a field of 0 gives 4.
- R12: Once a start has been issued and until a done pulse arrives, command writes other than the two reset codes are ignored. A reset code is accepted and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cmd_start | output | 1 | One-cycle operation start to the engines |
| cmd_code | output | 16 | Current command register value |
| buf_addr | output | 4 | Buffer address from buffer select |
| sec_count | output | 3 | Sector count, 1 to 4 |
| done_load | input | 1 | Load finished pulse |
| done_prog | input | 1 | Program finished pulse |
| done_erase | input | 1 | Erase finished pulse |
| done_misc | input | 1 | Other operation finished pulse |
| err_load | input | 1 | Load failure pulse |
| err_prog | input | 1 | Program failure pulse |
| err_erase | input | 1 | Erase failure pulse |
| irq | output | 1 | Interrupt pin, polarity set by configuration one |
| rdy | output | 1 | Ready pin |

## Verification
The assertions take the done and error inputs as pulses sampled on the clock, and they take the host to make at most one register write per cycle. They make no assumption that the engines answer only after a start. The bench drives every input only between clock edges and keeps each write strobe one cycle wide. Its random phase fires done and error pulses freely, including in the issue cycle, in the wait state and together with mask writes and reset commands. This exercises the ordering rules rather than hiding them.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int DW = 16;

    // register offsets
    localparam int OFF_CMD  = 0;
    localparam int OFF_CFG1 = 1;
    localparam int OFF_CFG2 = 2;
    localparam int OFF_STAT = 3;
    localparam int OFF_INT  = 4;
    localparam int OFF_BSEL = 5;

    // interrupt bit positions
    localparam int IB_MASTER = 15;
    localparam int IB_LOAD   = 7;
    localparam int IB_PROG   = 6;
    localparam int IB_ERASE  = 5;
    localparam int IB_RESET  = 4;

    // status bit positions
    localparam int SB_CMD   = 10;
    localparam int SB_ERASE = 11;
    localparam int SB_PROG  = 12;
    localparam int SB_LOAD  = 13;

    localparam logic [DW-1:0] STAT_ERR_MASK = 16'h3C00;
    localparam logic [DW-1:0] BSEL_KEEP     = 16'h0F03;

    localparam logic [DW-1:0] CFG1_INIT     = 16'h40C0;
    localparam logic [DW-1:0] CFG2_INIT     = 16'h0000;
    localparam logic [DW-1:0] BSEL_INIT     = 16'h0001;
    localparam logic [DW-1:0] INT_COLD_INIT = 16'h8080;
    localparam logic [DW-1:0] INT_WARM_INIT = 16'h8010;
    localparam logic [DW-1:0] CFG1_RD_MASK  = 16'hFFE0;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        CK_LOAD  = 3'd0,
        CK_PROG  = 3'd1,
        CK_ERASE = 3'd2,
        CK_MISC  = 3'd3,
        CK_RESET = 3'd4,
        CK_BAD   = 3'd5
    } cmd_kind_e;

endpackage

// File: rtl/fcr_cmd_decode.sv
module fcr_cmd_decode
    import fcr_pkg::*;
(
    input  logic [DW-1:0] code,
    output cmd_kind_e     kind
);
    always_comb begin
        unique case (code)
            16'h0000, 16'h0013:           kind = CK_LOAD;
            16'h0080, 16'h001A, 16'h001B: kind = CK_PROG;
            16'h0094, 16'h0095, 16'h0030: kind = CK_ERASE;
            16'h0023, 16'h0027, 16'h002A,
            16'h002C, 16'h0065, 16'h0071,
            16'h00B0:                     kind = CK_MISC;
            16'h00F0, 16'h00F3:           kind = CK_RESET;
            default:                      kind = CK_BAD;
        endcase
    end
endmodule

// File: rtl/fcr_cmd_seq.sv
module fcr_cmd_seq
    import fcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       int_pending,
    input  cmd_kind_e  kind,
    input  logic       any_done,
    output logic       accept,
    output logic       warm_rst,
    output logic       bad_cmd,
    output logic       start_op,
    output seq_state_e state
);
    seq_state_e state_nx;
    logic       launch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // acceptance and next state
    always_comb begin
        accept   = cmd_wr && !int_pending &&
                   ((state == SEQ_IDLE) || (kind == CK_RESET));
        warm_rst = accept && (kind == CK_RESET);
        bad_cmd  = accept && (kind == CK_BAD);
        launch   = accept && (kind inside {CK_LOAD, CK_PROG, CK_ERASE, CK_MISC});
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (launch) state_nx = SEQ_ISSUE;
            SEQ_ISSUE: state_nx = (warm_rst || any_done) ? SEQ_IDLE : SEQ_WAIT;
            SEQ_WAIT:  if (warm_rst || any_done) state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_op = (state == SEQ_ISSUE);
    end
endmodule

// File: rtl/fcr_event_regs.sv
module fcr_event_regs
    import fcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          int_wr,
    input  logic [DW-1:0] wdata,
    input  logic          bad_cmd,
    input  logic          done_load,
    input  logic          done_prog,
    input  logic          done_erase,
    input  logic          done_misc,
    input  logic          err_load,
    input  logic          err_prog,
    input  logic          err_erase,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] int_and, int_set, int_nx;
    logic [DW-1:0] stat_kept, stat_set, stat_nx;

    always_comb begin
        int_and = int_wr ? (int_q & wdata) : int_q;
        int_set = '0;
        int_set[IB_MASTER] = done_load | done_prog | done_erase | done_misc | bad_cmd;
        int_set[IB_LOAD]   = done_load;
        int_set[IB_PROG]   = done_prog;
        int_set[IB_ERASE]  = done_erase;
        int_nx = int_and | int_set;

        stat_kept = (int_wr && !int_and[IB_MASTER]) ? (stat_q & ~STAT_ERR_MASK) : stat_q;
        stat_set = '0;
        stat_set[SB_CMD]   = err_load | err_prog | err_erase | bad_cmd;
        stat_set[SB_LOAD]  = err_load;
        stat_set[SB_PROG]  = err_prog;
        stat_set[SB_ERASE] = err_erase;
        stat_nx = stat_kept | stat_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= INT_COLD_INIT;
            stat_q <= '0;
        end else if (warm_rst) begin
            int_q  <= INT_WARM_INIT;
            stat_q <= '0;
        end else begin
            int_q  <= int_nx;
            stat_q <= stat_nx;
        end
    end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              cmd_start,
    output logic [DW-1:0]     cmd_code,
    output logic [3:0]        buf_addr,
    output logic [2:0]        sec_count,
    input  logic              done_load,
    input  logic              done_prog,
    input  logic              done_erase,
    input  logic              done_misc,
    input  logic              err_load,
    input  logic              err_prog,
    input  logic              err_erase,
    output logic              irq,
    output logic              rdy
);
    logic [DW-1:0] cmd_q, cfg1_q, cfg2_q, bsel_q, int_q, stat_q;
    cmd_kind_e     kind;
    seq_state_e    seq_state;
    logic          accept, warm_rst, bad_cmd, start_op;
    logic          wr_cmd, wr_cfg1, wr_cfg2, wr_int, wr_bsel;

    assign wr_cmd  = reg_we && (reg_addr == ADDR_W'(OFF_CMD));
    assign wr_cfg1 = reg_we && (reg_addr == ADDR_W'(OFF_CFG1));
    assign wr_cfg2 = reg_we && (reg_addr == ADDR_W'(OFF_CFG2));
    assign wr_int  = reg_we && (reg_addr == ADDR_W'(OFF_INT));
    assign wr_bsel = reg_we && (reg_addr == ADDR_W'(OFF_BSEL));

    fcr_cmd_decode u_dec (
        .code (reg_wdata),
        .kind (kind)
    );

    fcr_cmd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (wr_cmd),
        .int_pending (int_q[IB_MASTER]),
        .kind        (kind),
        .any_done    (done_load | done_prog | done_erase | done_misc),
        .accept      (accept),
        .warm_rst    (warm_rst),
        .bad_cmd     (bad_cmd),
        .start_op    (start_op),
        .state       (seq_state)
    );

    fcr_event_regs u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst   (warm_rst),
        .int_wr     (wr_int),
        .wdata      (reg_wdata),
        .bad_cmd    (bad_cmd),
        .done_load  (done_load),
        .done_prog  (done_prog),
        .done_erase (done_erase),
        .done_misc  (done_misc),
        .err_load   (err_load),
        .err_prog   (err_prog),
        .err_erase  (err_erase),
        .int_q      (int_q),
        .stat_q     (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            cfg1_q <= CFG1_INIT;
            cfg2_q <= CFG2_INIT;
            bsel_q <= BSEL_INIT;
        end else if (warm_rst) begin
            cmd_q  <= '0;
            cfg1_q <= CFG1_INIT;
            cfg2_q <= CFG2_INIT;
            bsel_q <= BSEL_INIT;
        end else begin
            if (accept)  cmd_q  <= reg_wdata;
            if (wr_cfg1) cfg1_q <= reg_wdata;
            if (wr_cfg2) cfg2_q <= reg_wdata;
            if (wr_bsel) bsel_q <= reg_wdata & BSEL_KEEP;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFF_CMD):  reg_rdata = cmd_q;
            ADDR_W'(OFF_CFG1): reg_rdata = cfg1_q & CFG1_RD_MASK;
            ADDR_W'(OFF_CFG2): reg_rdata = cfg2_q;
            ADDR_W'(OFF_STAT): reg_rdata = stat_q;
            ADDR_W'(OFF_INT):  reg_rdata = int_q;
            ADDR_W'(OFF_BSEL): reg_rdata = bsel_q;
            default:           reg_rdata = '0;
        endcase
    end

    assign cmd_start = start_op;
    assign cmd_code  = cmd_q;
    assign buf_addr  = bsel_q[11:8];
    assign sec_count = (bsel_q[1:0] == 2'b00) ? 3'd4 : {1'b0, bsel_q[1:0]};
    assign irq       = int_q[IB_MASTER] ^ ~cfg1_q[6];
    assign rdy       = cfg1_q[7];

endmodule

// File: rtl/fcr_checker.sv
module fcr_checker
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic              cmd_start,
    input logic              rdy,
    input logic              done_load,
    input logic              err_load,
    input logic              err_prog,
    input logic              err_erase,
    input logic [DW-1:0]     int_q,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     cmd_q,
    input seq_state_e        seq_state
);
    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == ADDR_W'(OFF_CMD));

    AST_CFG1_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFF_CFG1)) |-> (reg_rdata[4:0] == 5'd0)); // R2

    AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_CFG1)) |=> (rdy == $past(reg_wdata[7]))); // R3

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_INT) && !reg_wdata[15] &&
         !err_load && !err_prog && !err_erase) |=> ((stat_q & STAT_ERR_MASK) == '0)); // R4

    AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && int_q[IB_MASTER]) |=> ($stable(cmd_q) && !cmd_start)); // R5

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R6

    AST_LOAD_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_load && !cmd_wr) |=> (int_q[IB_MASTER] && int_q[IB_LOAD])); // R9

    AST_PROG_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prog && !cmd_wr) |=> (stat_q[SB_PROG] && stat_q[SB_CMD])); // R10

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && seq_state != SEQ_IDLE && reg_wdata != 16'h00F0 && reg_wdata != 16'h00F3)
        |=> (!cmd_start && $stable(cmd_q))); // R12

endmodule

bind flash_cmd_regs fcr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cmd_start (cmd_start),
    .rdy       (rdy),
    .done_load (done_load),
    .err_load  (err_load),
    .err_prog  (err_prog),
    .err_erase (err_erase),
    .int_q     (int_q),
    .stat_q    (stat_q),
    .cmd_q     (cmd_q),
    .seq_state (seq_state)
);

// File: tb/flash_cmd_regs_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_start;
    logic [15:0] cmd_code;
    logic [3:0]  buf_addr;
    logic [2:0]  sec_count;
    logic [6:0]  pulses = '0;
    logic        irq, rdy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_cmd_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
        .cmd_code(cmd_code), .buf_addr(buf_addr), .sec_count(sec_count),
        .done_load(pulses[0]), .done_prog(pulses[1]), .done_erase(pulses[2]),
        .done_misc(pulses[3]), .err_load(pulses[4]), .err_prog(pulses[5]),
        .err_erase(pulses[6]), .irq(irq), .rdy(rdy)
    );

    // reference model state
    logic [15:0] m_cmd, m_cfg1, m_cfg2, m_stat, m_int, m_bs;
    int m_st;

    // 0 load, 1 prog, 2 erase, 3 misc, 4 reset, 5 unknown
    function automatic int kind_of(logic [15:0] c);
        case (c)
            16'h0000, 16'h0013: return 0;
            16'h0080, 16'h001A, 16'h001B: return 1;
            16'h0094, 16'h0095, 16'h0030: return 2;
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0065, 16'h0071, 16'h00B0: return 3;
            16'h00F0, 16'h00F3: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [15:0] rd_model(int a);
        case (a)
            0: return m_cmd;
            1: return m_cfg1 & 16'hFFE0;
            2: return m_cfg2;
            3: return m_stat;
            4: return m_int;
            5: return m_bs;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset(bit warm);
        m_cmd = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0; m_bs = 16'h0001;
        m_int = warm ? 16'h8010 : 16'h8080; m_st = 0;
    endtask

    task automatic model_step(bit we, int a, logic [15:0] wd, logic [6:0] p);
        int k = kind_of(wd);
        bit acc = we && a == 0 && !m_int[15] && (m_st == 0 || k == 4);
        bit dany = |p[3:0];
        logic [15:0] ia, sn;
        if (acc && k == 4) begin
            model_reset(1);
        end else begin
            ia = (we && a == 4) ? (m_int & wd) : m_int;
            sn = m_stat;
            if (we && a == 4 && !ia[15]) sn = sn & ~16'h3C00;
            if (p[4]) sn = sn | 16'h2400;
            if (p[5]) sn = sn | 16'h1400;
            if (p[6]) sn = sn | 16'h0C00;
            if (p[0]) ia = ia | 16'h8080;
            if (p[1]) ia = ia | 16'h8040;
            if (p[2]) ia = ia | 16'h8020;
            if (p[3]) ia = ia | 16'h8000;
            if (acc && k == 5) begin sn = sn | 16'h0400; ia = ia | 16'h8000; end
            if (acc) m_cmd = wd;
            if (we && a == 1) m_cfg1 = wd;
            if (we && a == 2) m_cfg2 = wd;
            if (we && a == 5) m_bs = wd & 16'h0F03;
            m_int = ia; m_stat = sn;
            case (m_st)
                0: m_st = (acc && k < 4) ? 1 : 0;
                default: m_st = dany ? 0 : 2;
            endcase
        end
    endtask

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // called at a negedge; reads every register through the bus
    task automatic verify(string tag);
        reg_we = 0; pulses = '0;
        chk(tag, "irq", {15'd0, irq}, {15'd0, m_int[15] ^ ~m_cfg1[6]});
        chk(tag, "rdy", {15'd0, rdy}, {15'd0, m_cfg1[7]});
        chk(tag, "cmd_start", {15'd0, cmd_start}, {15'd0, m_st == 1});
        if (m_st == 1) chk(tag, "cmd_code", cmd_code, m_cmd);
        chk(tag, "buf_addr", {12'd0, buf_addr}, {12'd0, m_bs[11:8]});
        chk(tag, "sec_count", {13'd0, sec_count},
            (m_bs[1:0] == 0) ? 16'd4 : {14'd0, m_bs[1:0]});
        for (int a = 0; a < 7; a++) begin
            reg_addr = 4'(a);
            #0.2;
            chk(tag, $sformatf("reg%0d", a), reg_rdata, rd_model(a));
        end
    endtask

    task automatic step(bit we, int a, logic [15:0] wd, logic [6:0] p);
        reg_we = we; reg_addr = 4'(a); reg_wdata = wd; pulses = p;
        @(posedge clk);
        model_step(we, a, wd, p);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        verify("R1");

        step(1, 1, 16'hFFFF, 0); verify("R2");
        step(1, 2, 16'hA5C3, 0); verify("R2");
        step(1, 1, 16'h0000, 0); verify("R3");
        step(1, 1, 16'h40C0, 0); verify("R3");

        step(1, 4, 16'h7FFF, 0); verify("R4");
        step(0, 0, 0, 7'b0100000); verify("R10");
        step(0, 0, 0, 7'b1010000); verify("R10");
        step(1, 4, 16'hFFFF, 0); verify("R4");

        step(1, 0, 16'h0080, 0); verify("R6");
        step(1, 0, 16'h0000, 0); verify("R12");
        step(0, 0, 0, 7'b0000010); verify("R9");
        step(1, 0, 16'h0013, 0); verify("R5");
        step(1, 4, 16'h0000, 0); verify("R4");
        step(1, 0, 16'h0042, 0); verify("R7");
        step(1, 4, 16'h0000, 0); verify("R4");

        step(1, 0, 16'h0094, 0); verify("R6");
        step(1, 4, 16'h7FFF, 7'b0000100); verify("R9");
        step(1, 4, 16'h0000, 0);
        step(1, 5, 16'hFFF0, 0); verify("R11");
        step(1, 5, 16'h0102, 0); verify("R11");

        step(1, 0, 16'h0013, 0); verify("R6");
        step(0, 0, 0, 0); verify("R12");
        step(1, 0, 16'h00F3, 7'b0000001); verify("R8");
        step(1, 4, 16'h0000, 0);
        step(1, 1, 16'h1234, 0);
        step(1, 0, 16'h00F0, 0); verify("R8");

        void'($urandom(32'h5EED));
        for (int i = 0; i < 1500; i++) begin
            int sel = $urandom_range(0, 9);
            int a;
            logic [15:0] wd = 16'($urandom);
            logic [6:0] p = '0;
            for (int b = 0; b < 7; b++) if ($urandom_range(0, 9) == 0) p[b] = 1'b1;
            case (sel)
                0, 1: begin
                    a = 0;
                    case ($urandom_range(0, 5))
                        0: wd = 16'h0000; 1: wd = 16'h0080; 2: wd = 16'h0095;
                        3: wd = 16'h002C; 4: wd = ($urandom_range(0, 3) == 0) ? 16'h00F3 : 16'h00F0;
                        default: wd = 16'($urandom);
                    endcase
                end
                2, 3, 4: begin a = 4; if ($urandom_range(0, 1) == 0) wd = 16'h0000; end
                5: a = 1;
                6: a = 2;
                7: a = 5;
                8: a = 3;
                default: a = $urandom_range(6, 15);
            endcase
            step($urandom_range(0, 4) != 0, a, wd, p);
            verify("R9 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule